// File: doc/BRIEF.md
# Self-Routing 8x8 Butterfly Switching Fabric

This block moves fixed-size cells from eight input lines to eight output lines through three ranks of 2x2 steering elements. A cell is a valid flag, a 3-bit destination port number and a payload word. All eight inputs are sampled together once per clock, and that set of cells is called a slot. No central scheduler exists. Each element reads one bit of a cell's destination and sends the cell to its upper output when that bit is 0, or to its lower output when it is 1. After the last rank, each cell sits on the output line whose number equals its destination.

Two valid cells that reach the same element may ask for the same output. When they do, the cell on the upper input goes through and the other is discarded. A drop flag for that element rises for that slot. A collision can happen when both cells are bound for the same port (output blocking). It can also happen when the cells are bound for different ports but share a path through the fabric (internal blocking). Every rank has a register at its end, so a slot reaches the outputs three clock edges after it is sampled. Each drop flag is delayed so that it appears in the same cycle as the slot that caused it. A new slot can enter on every clock.

Top module: `bfly_fabric`

## Requirements
- R1: While reset is asserted, and until the first slot reaches the outputs, `out_valid`, `out_data` and `cell_drop` are all zero.
- R2: The cells of a slot that is sampled on clock edge k appear on the outputs right after edge k+2. Before that edge the outputs show nothing from that slot.
- R3: A lone valid cell on any input i with any destination d appears only on output d. Its payload is unchanged and no drop flag is raised.
- R4: Rank s (s = 0, 1, 2) steers on destination bit 2-s. It pairs the two lines whose numbers differ only in bit 2-s. Its upper output feeds the line with that bit 0 and its lower output feeds the line with that bit 1.
- R5: When two valid cells at one element ask for the same output, the cell from the lower-numbered line wins. Drop bit s*4+e pulses for that slot, where e is the element's line number with bit 2-s removed.
- R6: An input whose valid flag is low never causes a collision and never produces a valid output, whatever its destination or payload. An output whose valid flag is low carries an all-zero payload.
- R7: Two valid cells with the same destination deliver exactly one cell to that output and raise exactly one drop bit.
- R8: Two valid cells with different destinations can still collide inside the fabric. For example, inputs 0 and 4 bound for ports 0 and 1 meet at rank-0 element 0. Only the cell from input 0 arrives, and drop bit 0 is raised.
- R9: Slots entered on consecutive clocks are handled independently. Each slot's outputs and drops depend only on its own cells.
- R10: For every slot, the number of valid input cells equals the number of valid output cells plus the number of drop bits that are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. One slot is sampled per rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| in_valid | input | 8 | Per-input cell present flag. |
| in_dest | input | 24 | Destination port for each input. Input i uses bits [3i+2:3i]. |
| in_data | input | 128 | Payload for each input. Input i uses bits [16i+15:16i]. |
| out_valid | output | 8 | Per-output cell delivered flag. |
| out_data | output | 128 | Payload for each output. Output j uses bits [16j+15:16j]. |
| cell_drop | output | 12 | Per-element collision pulse. Bit s*4+e belongs to element e of rank s. |

## Verification
Delivery and dropping can happen at the same element in the same slot. The winning cell is forwarded while the losing one is discarded and flagged. The bench provokes this with an exhaustive sweep over every pair of inputs and every pair of destinations. That sweep covers both output blocking and path sharing that leads to internal blocking. Each pair is judged against an arithmetic model that traces each cell rank by rank and lets the lower-numbered line keep the contested output. The model predicts the delivered payloads, the surviving port and the exact drop bit. Back-to-back random slots with the fabric fully pipelined show that a drop in one slot never leaks into its neighbours.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;

    // Lower-numbered line of element e in a rank that steers on bit p:
    // insert a 0 at bit position p of e.
    function automatic int unsigned upper_line(input int unsigned p, input int unsigned e);
        int unsigned low_mask;
        low_mask = (32'd1 << p) - 32'd1;
        return ((e >> p) << (p + 32'd1)) | (e & low_mask);
    endfunction

endpackage

// File: rtl/bfly_elem.sv
`timescale 1ns/1ps
module bfly_elem #(
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SEL_BIT = 0
) (
    input  logic              a_v,
    input  logic [ADDR_W-1:0] a_d,
    input  logic [DATA_W-1:0] a_x,
    input  logic              b_v,
    input  logic [ADDR_W-1:0] b_d,
    input  logic [DATA_W-1:0] b_x,
    output logic              u_v,
    output logic [ADDR_W-1:0] u_d,
    output logic [DATA_W-1:0] u_x,
    output logic              l_v,
    output logic [ADDR_W-1:0] l_d,
    output logic [DATA_W-1:0] l_x,
    output logic              clash
);

    logic a_sel;
    logic b_sel;

    assign a_sel = a_d[SEL_BIT];
    assign b_sel = b_d[SEL_BIT];

    // Upper input (a) is examined first on both outputs, so it wins ties.
    always_comb begin
        u_v = 1'b0;
        u_d = '0;
        u_x = '0;
        if (a_v && !a_sel) begin
            u_v = 1'b1;
            u_d = a_d;
            u_x = a_x;
        end else if (b_v && !b_sel) begin
            u_v = 1'b1;
            u_d = b_d;
            u_x = b_x;
        end
    end

    always_comb begin
        l_v = 1'b0;
        l_d = '0;
        l_x = '0;
        if (a_v && a_sel) begin
            l_v = 1'b1;
            l_d = a_d;
            l_x = a_x;
        end else if (b_v && b_sel) begin
            l_v = 1'b1;
            l_d = b_d;
            l_x = b_x;
        end
    end

    assign clash = a_v && b_v && (a_sel == b_sel);

endmodule

// File: rtl/bfly_stage.sv
`timescale 1ns/1ps
module bfly_stage #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STAGE  = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [(1<<ADDR_W)-1:0]   in_v,
    input  logic [(1<<ADDR_W)*ADDR_W-1:0] in_d,
    input  logic [(1<<ADDR_W)*DATA_W-1:0] in_x,
    input  logic [ADDR_W*(1<<ADDR_W)/2-1:0] in_drop,
    output logic [(1<<ADDR_W)-1:0]   out_v,
    output logic [(1<<ADDR_W)*ADDR_W-1:0] out_d,
    output logic [(1<<ADDR_W)*DATA_W-1:0] out_x,
    output logic [ADDR_W*(1<<ADDR_W)/2-1:0] out_drop
);

    localparam int unsigned N      = 1 << ADDR_W;
    localparam int unsigned HALF   = N / 2;
    localparam int unsigned DROP_W = ADDR_W * HALF;
    localparam int unsigned SEL    = ADDR_W - 1 - STAGE;

    logic [N-1:0]        nxt_v;
    logic [N*ADDR_W-1:0] nxt_d;
    logic [N*DATA_W-1:0] nxt_x;
    logic [HALF-1:0]     clash_vec;
    logic [DROP_W-1:0]   drop_here;

    for (genvar e = 0; e < HALF; e++) begin : g_elem
        localparam int unsigned LO = bfly_pkg::upper_line(SEL, e);
        localparam int unsigned HI = LO + (1 << SEL);

        bfly_elem #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .SEL_BIT(SEL)
        ) elem_i (
            .a_v  (in_v[LO]),
            .a_d  (in_d[LO*ADDR_W +: ADDR_W]),
            .a_x  (in_x[LO*DATA_W +: DATA_W]),
            .b_v  (in_v[HI]),
            .b_d  (in_d[HI*ADDR_W +: ADDR_W]),
            .b_x  (in_x[HI*DATA_W +: DATA_W]),
            .u_v  (nxt_v[LO]),
            .u_d  (nxt_d[LO*ADDR_W +: ADDR_W]),
            .u_x  (nxt_x[LO*DATA_W +: DATA_W]),
            .l_v  (nxt_v[HI]),
            .l_d  (nxt_d[HI*ADDR_W +: ADDR_W]),
            .l_x  (nxt_x[HI*DATA_W +: DATA_W]),
            .clash(clash_vec[e])
        );
    end

    always_comb begin
        drop_here = '0;
        drop_here[STAGE*HALF +: HALF] = clash_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v    <= '0;
            out_d    <= '0;
            out_x    <= '0;
            out_drop <= '0;
        end else begin
            out_v    <= nxt_v;
            out_d    <= nxt_d;
            out_x    <= nxt_x;
            out_drop <= in_drop | drop_here;
        end
    end

endmodule

// File: rtl/bfly_fabric.sv
`timescale 1ns/1ps
module bfly_fabric #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [(1<<ADDR_W)-1:0]              in_valid,
    input  logic [(1<<ADDR_W)*ADDR_W-1:0]       in_dest,
    input  logic [(1<<ADDR_W)*DATA_W-1:0]       in_data,
    output logic [(1<<ADDR_W)-1:0]              out_valid,
    output logic [(1<<ADDR_W)*DATA_W-1:0]       out_data,
    output logic [ADDR_W*(1<<ADDR_W)/2-1:0]     cell_drop
);

    localparam int unsigned N      = 1 << ADDR_W;
    localparam int unsigned STAGES = ADDR_W;
    localparam int unsigned DROP_W = ADDR_W * N / 2;

    logic [N-1:0]        lane_v    [STAGES+1];
    logic [N*ADDR_W-1:0] lane_d    [STAGES+1];
    logic [N*DATA_W-1:0] lane_x    [STAGES+1];
    logic [DROP_W-1:0]   lane_drop [STAGES+1];

    assign lane_v[0]    = in_valid;
    assign lane_d[0]    = in_dest;
    assign lane_x[0]    = in_data;
    assign lane_drop[0] = '0;

    for (genvar s = 0; s < STAGES; s++) begin : g_rank
        bfly_stage #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W),
            .STAGE (s)
        ) rank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (lane_v[s]),
            .in_d    (lane_d[s]),
            .in_x    (lane_x[s]),
            .in_drop (lane_drop[s]),
            .out_v   (lane_v[s+1]),
            .out_d   (lane_d[s+1]),
            .out_x   (lane_x[s+1]),
            .out_drop(lane_drop[s+1])
        );
    end

    assign out_valid = lane_v[STAGES];
    assign out_data  = lane_x[STAGES];
    assign cell_drop = lane_drop[STAGES];

endmodule

// File: rtl/bfly_fabric_chk.sv
`timescale 1ns/1ps
module bfly_fabric_chk #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [(1<<ADDR_W)-1:0]          in_valid,
    input logic [(1<<ADDR_W)-1:0]          out_valid,
    input logic [(1<<ADDR_W)*DATA_W-1:0]   out_data,
    input logic [(1<<ADDR_W)*ADDR_W-1:0]   out_dest,
    input logic [ADDR_W*(1<<ADDR_W)/2-1:0] cell_drop
);

    localparam int unsigned N = 1 << ADDR_W;

    // Edges seen since reset release, saturating at the pipeline depth 3.
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    always @(posedge clk) begin
        if (rst_n && age == 2'd0) begin
            p_reset_clear_r1: assert (out_valid == '0 && cell_drop == '0 && out_data == '0)
                else $error("R1 outputs not clear after reset");
        end
    end

    p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |->
        ($countones($past(in_valid, 3)) == $countones(out_valid) + $countones(cell_drop)))
        else $error("R10 cell count not conserved");

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(in_valid, 3) == '0) |-> (out_valid == '0 && cell_drop == '0))
        else $error("R6 empty slot produced activity");

    p_drop_needs_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && cell_drop != '0) |-> ($countones($past(in_valid, 3)) >= 2))
        else $error("R5 drop without two cells");

    for (genvar j = 0; j < N; j++) begin : g_port
        p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[j] |-> (out_data[j*DATA_W +: DATA_W] == '0))
            else $error("R6 payload on empty output");

        p_lands_on_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (out_dest[j*ADDR_W +: ADDR_W] == ADDR_W'(j)))
            else $error("R3 cell on wrong output");
    end

endmodule

bind bfly_fabric bfly_fabric_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_dest (lane_d[STAGES]),
    .cell_drop(cell_drop)
);

// File: tb/bfly_fabric_tb_top.sv
`timescale 1ns/1ps
module bfly_fabric_tb_top;

    localparam int AW   = 3;
    localparam int N    = 1 << AW;
    localparam int DW   = 16;
    localparam int HALF = N / 2;
    localparam int DRW  = AW * HALF;
    localparam int NSLOT = 400;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*AW-1:0] in_dest = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    out_valid;
    logic [N*DW-1:0] out_data;
    logic [DRW-1:0]  cell_drop;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    always #5 clk = ~clk;

    bfly_fabric #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_dest  (in_dest),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data),
        .cell_drop(cell_drop)
    );

    // Reference: trace each cell rank by rank; lower line claims a contested output first.
    task automatic model(input logic [N-1:0] v, input logic [N*AW-1:0] d, input logic [N*DW-1:0] x,
                         output logic [N-1:0] ov, output logic [N*DW-1:0] ox, output logic [DRW-1:0] dr);
        logic [N-1:0]    cv, nv;
        logic [N*AW-1:0] cd, nd;
        logic [N*DW-1:0] cx, nx;
        cv = v; cd = d; cx = x; dr = '0;
        for (int s = 0; s < AW; s++) begin
            int p;
            p = AW - 1 - s;
            nv = '0; nd = '0; nx = '0;
            for (int ln = 0; ln < N; ln++) begin
                if (cv[ln]) begin
                    int tgt;
                    tgt = (ln & ~(1 << p)) | (int'(cd[ln*AW + p]) << p);
                    if (nv[tgt]) begin
                        int e;
                        e = ((ln >> (p + 1)) << p) | (ln & ((1 << p) - 1));
                        dr[s*HALF + e] = 1'b1;
                    end else begin
                        nv[tgt] = 1'b1;
                        nd[tgt*AW +: AW] = cd[ln*AW +: AW];
                        nx[tgt*DW +: DW] = cx[ln*DW +: DW];
                    end
                end
            end
            cv = nv; cd = nd; cx = nx;
        end
        ov = cv; ox = cx;
    endtask

    task automatic check(input string tag, input logic [N-1:0] ev, input logic [N*DW-1:0] ex,
                         input logic [DRW-1:0] ed);
        n_tests++;
        if (out_valid !== ev || out_data !== ex || cell_drop !== ed) begin
            n_fail++;
            $display("FAIL %s: valid=%h data=%h drop=%h expected valid=%h data=%h drop=%h",
                     tag, out_valid, out_data, cell_drop, ev, ex, ed);
        end
    endtask

    function automatic logic [N*DW-1:0] payloads(input int salt);
        logic [N*DW-1:0] r;
        for (int i = 0; i < N; i++) r[i*DW +: DW] = DW'(16'hA000 + i * 16'h0111 + salt);
        return r;
    endfunction

    // One isolated slot: drive, then sample right after the third edge.
    task automatic run_slot(input string tag, input logic [N-1:0] v, input logic [N*AW-1:0] d,
                            input logic [N*DW-1:0] x, input bit probe_early);
        logic [N-1:0]    ev;
        logic [N*DW-1:0] ex;
        logic [DRW-1:0]  ed;
        model(v, d, x, ev, ex, ed);
        @(negedge clk);
        in_valid = v; in_dest = d; in_data = x;
        @(posedge clk);
        @(negedge clk);
        in_valid = '0; in_dest = '0; in_data = '0;
        @(posedge clk);
        @(negedge clk);
        if (probe_early) check("R2 early", '0, '0, '0);
        @(posedge clk);
        @(negedge clk);
        check(tag, ev, ex, ed);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", '0, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", '0, '0, '0);

        // R2: latency probe on one cell
        begin
            logic [N*AW-1:0] d;
            d = '0; d[2*AW +: AW] = 3'd5;
            run_slot("R2 arrival", 8'b0000_0100, d, payloads(7), 1'b1);
        end

        // R3: every lone input/destination combination
        for (int i = 0; i < N; i++) begin
            for (int dd = 0; dd < N; dd++) begin
                logic [N*AW-1:0] d;
                d = '0;
                d[i*AW +: AW] = AW'(dd);
                run_slot("R3 lone cell", N'(1) << i, d, payloads(i * 8 + dd), 1'b0);
            end
        end

        // R7: inputs 0 and 1 both to port 3; input 0 wins at rank 2 element 1 (R5 drop bit 9)
        begin
            logic [N*AW-1:0] d;
            logic [N*DW-1:0] x;
            logic [N*DW-1:0] ex;
            logic [DRW-1:0]  ed;
            d = '0; d[0 +: AW] = 3'd3; d[AW +: AW] = 3'd3;
            x = payloads(99);
            ex = '0; ex[3*DW +: DW] = x[0 +: DW];
            ed = '0; ed[9] = 1'b1;
            @(negedge clk);
            in_valid = 8'b0000_0011; in_dest = d; in_data = x;
            @(posedge clk); @(negedge clk);
            in_valid = '0; in_dest = '0; in_data = '0;
            @(posedge clk); @(posedge clk); @(negedge clk);
            check("R7/R5 shared port", 8'b0000_1000, ex, ed);
        end

        // R8: inputs 0 and 4, ports 0 and 1, meet at rank 0 element 0
        begin
            logic [N*AW-1:0] d;
            logic [N*DW-1:0] x;
            logic [N*DW-1:0] ex;
            logic [DRW-1:0]  ed;
            d = '0; d[0 +: AW] = 3'd0; d[4*AW +: AW] = 3'd1;
            x = payloads(55);
            ex = '0; ex[0 +: DW] = x[0 +: DW];
            ed = '0; ed[0] = 1'b1;
            @(negedge clk);
            in_valid = 8'b0001_0001; in_dest = d; in_data = x;
            @(posedge clk); @(negedge clk);
            in_valid = '0; in_dest = '0; in_data = '0;
            @(posedge clk); @(posedge clk); @(negedge clk);
            check("R8 internal block", 8'b0000_0001, ex, ed);
        end

        // R6: invalid inputs carry colliding destinations and payloads; only input 3 is valid
        begin
            logic [N*AW-1:0] d;
            logic [N*DW-1:0] ex;
            d = '0;
            for (int i = 0; i < N; i++) d[i*AW +: AW] = 3'd6;
            ex = '0; ex[6*DW +: DW] = payloads(3)[3*DW +: DW];
            run_slot("R6 ignored empties", 8'b0000_1000, d, payloads(3), 1'b0);
            run_slot("R6 all empty", 8'b0000_0000, d, payloads(4), 1'b0);
        end

        // R4/R5: every pair of inputs with every pair of destinations
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                for (int di = 0; di < N; di++) begin
                    for (int dj = 0; dj < N; dj++) begin
                        logic [N*AW-1:0] d;
                        d = '0;
                        d[i*AW +: AW] = AW'(di);
                        d[j*AW +: AW] = AW'(dj);
                        run_slot("R4/R5 pair", (N'(1) << i) | (N'(1) << j), d,
                                 payloads(i + j * 3 + di * 5 + dj), 1'b0);
                    end
                end
            end
        end

        // R9/R10: back-to-back random slots
        begin
            logic [N-1:0]    rv [4];
            logic [N*DW-1:0] rx [4];
            logic [DRW-1:0]  rd [4];
            int              rc [4];
            for (int k = 0; k < NSLOT + 3; k++) begin
                @(negedge clk);
                if (k >= 3) begin
                    check("R9 pipelined", rv[(k-3)%4], rx[(k-3)%4], rd[(k-3)%4]);
                    n_tests++;
                    if (rc[(k-3)%4] != $countones(out_valid) + $countones(cell_drop)) begin
                        n_fail++;
                        $display("FAIL R10: delivered+dropped=%0d expected %0d",
                                 $countones(out_valid) + $countones(cell_drop), rc[(k-3)%4]);
                    end
                end
                if (k < NSLOT) begin
                    logic [N-1:0]    v;
                    logic [N*AW-1:0] d;
                    logic [N*DW-1:0] x;
                    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                    v = lfsr[7:0];
                    d = lfsr[31:8];
                    x = payloads(int'(lfsr[15:0]));
                    model(v, d, x, rv[k%4], rx[k%4], rd[k%4]);
                    rc[k%4] = $countones(v);
                    in_valid = v; in_dest = d; in_data = x;
                end else begin
                    in_valid = '0; in_dest = '0; in_data = '0;
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule